// File: doc/BRIEF.md
# Interrupt presentation priority controller

This block is the presentation stage of an interrupt system for one processor. It holds at most one pending interrupt, decides whether an arriving interrupt is favoured enough to be shown to the processor, and drives the processor's interrupt line. It keeps a 32-bit status word: the processor's current priority sits in the upper byte and the number of the pending source in the lower 24 bits. A pending-priority register and an inter-processor-interrupt (IPI) priority register complete its state. Priorities are inverted: a smaller number is more favoured, and 0xFF means fully masked.

The processor drives four commands: set current priority, set IPI priority, accept, and end-of-interrupt (EOI). The source layer delivers interrupts, each a source number with a priority. The block sends back a reject pulse naming a source that it refused or displaced. It raises a resend request when the source layer should offer its rejected interrupts again, and it reports the source number of each EOI. An accept returns the full status word. Each operation goes through a small engine with three states. ST_IDLE takes one operation. Transition T_TAKE moves it to ST_EXEC, which applies the operation. From ST_EXEC, T_DONE returns to ST_IDLE, or T_RESEND moves to ST_RESEND when a resend is owed. ST_RESEND runs the IPI check, pulses the resend request, and returns through T_BACK.

Top module: `intr_present_ctrl`

## Requirements
- R1: After reset the status word is 0 (priority byte 0x00, no source), the pending priority is 0 and the IPI priority is 0xFF; the interrupt line is low and both ready outputs are high.
- R2: The status word carries the current priority in bits 31:24 and the pending source in bits 23:0; source 0 means nothing is pending, and the source layer never delivers source 0.
- R3: A delivery is rejected, with a reject pulse carrying its own source, when its priority is not below the current priority or when a pending source has a priority less than or equal to its own.
- R4: Any other delivery displaces the pending source, which is rejected with its own number; the new source and priority are latched and the interrupt line goes high.
- R5: Accept (cmd_op 2) pulses acc_valid with the status word as it was, lowers the line, then sets the priority byte to the pending priority and clears the source field.
- R6: Set current priority (cmd_op 0, value in cmd_data[7:0]) with a value below the old one ejects the pending source when its priority is greater than or equal to the new value: the source field clears, the line drops and the source is rejected.
- R7: Set current priority with a value not below the old one requests a resend when nothing is pending.
- R8: Set IPI priority (cmd_op 1, value in cmd_data[7:0]) stores the value and runs the IPI check when the value is below the current priority.
- R9: The IPI check does nothing when a pending source has priority less than or equal to the IPI priority; otherwise it rejects any pending source, latches source IPI_SRC (default 2) with the IPI priority as pending priority, and raises the line.
- R10: EOI (cmd_op 3) pulses eoi_valid with cmd_data[23:0] on eoi_src, loads the priority byte from cmd_data[31:24], and requests a resend when nothing is pending; every resend first runs the IPI check when the IPI priority is below the current priority.
- R11: One operation at a time: a taken operation completes two cycles later, or three when it requests a resend; both ready outputs stay low meanwhile, and a delivery wins over a command offered in the same cycle.
- R12: Reject, resend, accept and EOI outputs are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Command code: 0 priority, 1 IPI, 2 accept, 3 EOI |
| cmd_data | input | 32 | Command argument |
| cmd_ready | output | 1 | Command taken when high with cmd_valid |
| dlv_valid | input | 1 | Delivery offered |
| dlv_src | input | 24 | Delivered source number |
| dlv_prio | input | 8 | Delivered priority |
| dlv_ready | output | 1 | Delivery taken when high with dlv_valid |
| irq_out | output | 1 | Processor interrupt line |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Rejected source |
| resend_req | output | 1 | Resend request pulse |
| acc_valid | output | 1 | Accept result pulse |
| acc_word | output | 32 | Status word returned by accept |
| eoi_valid | output | 1 | EOI pulse |
| eoi_src | output | 24 | Completed source |

## Verification
The bench targets the equality edges. A delivery whose priority equals the pending priority must be rejected; a design that used a strict compare would displace it. Lowering the current priority to exactly the pending priority must eject; an off-by-one design would keep a source that is no longer favoured. An EOI that reopens the priority while an IPI request is below it must re-raise the IPI in the resend cycle; a design that skipped that check would leave the line low. A reset value other than 0xFF in the IPI register would show up as a spurious IPI on the first resend.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    typedef enum logic [2:0] {
        OPK_CPPR    = 3'd0,
        OPK_IPI     = 3'd1,
        OPK_ACCEPT  = 3'd2,
        OPK_EOI     = 3'd3,
        OPK_DELIVER = 3'd4
    } ipc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_RESEND = 2'd2
    } ipc_state_e;
endpackage

// File: rtl/ipc_seq.sv
module ipc_seq
    import ipc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       dlv_valid,
    input  logic       want_resend,
    output ipc_state_e state,
    output logic       cmd_ready,
    output logic       dlv_ready,
    output logic       take_cmd,
    output logic       take_dlv
);
    ipc_state_e state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions T_TAKE, T_DONE, T_RESEND, T_BACK
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid || dlv_valid) state_nxt = ST_EXEC;
            ST_EXEC:   state_nxt = want_resend ? ST_RESEND : ST_IDLE;
            ST_RESEND: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // outputs: a delivery wins over a command in the same cycle
    always_comb begin
        dlv_ready = (state == ST_IDLE);
        cmd_ready = (state == ST_IDLE) && !dlv_valid;
        take_dlv  = dlv_valid && dlv_ready;
        take_cmd  = cmd_valid && cmd_ready;
    end
endmodule

// File: rtl/ipc_eval.sv
module ipc_eval
    import ipc_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2,
    localparam int WORD_W = SRC_W + PRIO_W
) (
    input  ipc_state_e          state,
    input  ipc_op_e             op,
    input  logic [WORD_W-1:0]   op_word,
    input  logic [PRIO_W-1:0]   cur_cppr,
    input  logic [SRC_W-1:0]    cur_src,
    input  logic [PRIO_W-1:0]   cur_pprio,
    input  logic [PRIO_W-1:0]   cur_mfrr,
    input  logic                cur_irq,
    output logic [PRIO_W-1:0]   n_cppr,
    output logic [SRC_W-1:0]    n_src,
    output logic [PRIO_W-1:0]   n_pprio,
    output logic [PRIO_W-1:0]   n_mfrr,
    output logic                n_irq,
    output logic                rej_fire,
    output logic [SRC_W-1:0]    rej_id,
    output logic                resend_fire,
    output logic                want_resend,
    output logic                acc_fire,
    output logic [WORD_W-1:0]   acc_snap,
    output logic                eoi_fire,
    output logic [SRC_W-1:0]    eoi_id
);
    localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

    logic [PRIO_W-1:0] arg_lo;
    logic [PRIO_W-1:0] arg_hi;
    logic [SRC_W-1:0]  arg_src;
    logic [PRIO_W-1:0] ipi_prio;
    logic              has_pend;
    logic              ipi_blocked;

    assign arg_lo      = op_word[PRIO_W-1:0];
    assign arg_hi      = op_word[WORD_W-1:SRC_W];
    assign arg_src     = op_word[SRC_W-1:0];
    assign ipi_prio    = (state == ST_EXEC) ? arg_lo : cur_mfrr;
    assign has_pend    = (cur_src != '0);
    assign ipi_blocked = has_pend && (cur_pprio <= ipi_prio);

    always_comb begin
        n_cppr      = cur_cppr;
        n_src       = cur_src;
        n_pprio     = cur_pprio;
        n_mfrr      = cur_mfrr;
        n_irq       = cur_irq;
        rej_fire    = 1'b0;
        rej_id      = '0;
        resend_fire = 1'b0;
        want_resend = 1'b0;
        acc_fire    = 1'b0;
        acc_snap    = '0;
        eoi_fire    = 1'b0;
        eoi_id      = '0;
        unique case (state)
            ST_EXEC: begin
                unique case (op)
                    OPK_DELIVER: begin
                        if ((arg_hi >= cur_cppr) || (has_pend && (cur_pprio <= arg_hi))) begin
                            rej_fire = 1'b1;
                            rej_id   = arg_src;
                        end else begin
                            if (has_pend) begin
                                rej_fire = 1'b1;
                                rej_id   = cur_src;
                            end
                            n_src   = arg_src;
                            n_pprio = arg_hi;
                            n_irq   = 1'b1;
                        end
                    end
                    OPK_CPPR: begin
                        n_cppr = arg_lo;
                        if (arg_lo < cur_cppr) begin
                            if (has_pend && (arg_lo <= cur_pprio)) begin
                                n_src    = '0;
                                n_irq    = 1'b0;
                                rej_fire = 1'b1;
                                rej_id   = cur_src;
                            end
                        end else if (!has_pend) begin
                            want_resend = 1'b1;
                        end
                    end
                    OPK_IPI: begin
                        n_mfrr = arg_lo;
                        if ((arg_lo < cur_cppr) && !ipi_blocked) begin
                            if (has_pend) begin
                                rej_fire = 1'b1;
                                rej_id   = cur_src;
                            end
                            n_src   = IPI_ID;
                            n_pprio = arg_lo;
                            n_irq   = 1'b1;
                        end
                    end
                    OPK_ACCEPT: begin
                        acc_fire = 1'b1;
                        acc_snap = {cur_cppr, cur_src};
                        n_cppr   = cur_pprio;
                        n_src    = '0;
                        n_irq    = 1'b0;
                    end
                    OPK_EOI: begin
                        eoi_fire = 1'b1;
                        eoi_id   = arg_src;
                        n_cppr   = arg_hi;
                        if (!has_pend) want_resend = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_RESEND: begin
                resend_fire = 1'b1;
                if ((cur_mfrr < cur_cppr) && !ipi_blocked) begin
                    if (has_pend) begin
                        rej_fire = 1'b1;
                        rej_id   = cur_src;
                    end
                    n_src   = IPI_ID;
                    n_pprio = cur_mfrr;
                    n_irq   = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ipc_regs.sv
module ipc_regs
    import ipc_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    localparam int WORD_W = SRC_W + PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_cmd,
    input  logic              take_dlv,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRIO_W-1:0] dlv_prio,
    input  logic [PRIO_W-1:0] n_cppr,
    input  logic [SRC_W-1:0]  n_src,
    input  logic [PRIO_W-1:0] n_pprio,
    input  logic [PRIO_W-1:0] n_mfrr,
    input  logic              n_irq,
    input  logic              rej_fire,
    input  logic [SRC_W-1:0]  rej_id,
    input  logic              resend_fire,
    input  logic              acc_fire,
    input  logic [WORD_W-1:0] acc_snap,
    input  logic              eoi_fire,
    input  logic [SRC_W-1:0]  eoi_id,
    output ipc_op_e           op,
    output logic [WORD_W-1:0] op_word,
    output logic [PRIO_W-1:0] cur_cppr,
    output logic [SRC_W-1:0]  cur_src,
    output logic [PRIO_W-1:0] cur_pprio,
    output logic [PRIO_W-1:0] cur_mfrr,
    output logic              cur_irq,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              resend_req,
    output logic              acc_valid,
    output logic [WORD_W-1:0] acc_word,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src
);
    // operation latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op      <= OPK_CPPR;
            op_word <= '0;
        end else if (take_dlv) begin
            op      <= OPK_DELIVER;
            op_word <= {dlv_prio, dlv_src};
        end else if (take_cmd) begin
            op      <= ipc_op_e'({1'b0, cmd_op});
            op_word <= cmd_data;
        end
    end

    // presentation state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cppr  <= '0;
            cur_src   <= '0;
            cur_pprio <= '0;
            cur_mfrr  <= '1;
            cur_irq   <= 1'b0;
        end else begin
            cur_cppr  <= n_cppr;
            cur_src   <= n_src;
            cur_pprio <= n_pprio;
            cur_mfrr  <= n_mfrr;
            cur_irq   <= n_irq;
        end
    end

    // result pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rej_valid  <= 1'b0;
            rej_src    <= '0;
            resend_req <= 1'b0;
            acc_valid  <= 1'b0;
            acc_word   <= '0;
            eoi_valid  <= 1'b0;
            eoi_src    <= '0;
        end else begin
            rej_valid  <= rej_fire;
            resend_req <= resend_fire;
            acc_valid  <= acc_fire;
            eoi_valid  <= eoi_fire;
            if (rej_fire) rej_src  <= rej_id;
            if (acc_fire) acc_word <= acc_snap;
            if (eoi_fire) eoi_src  <= eoi_id;
        end
    end
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl
    import ipc_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2,
    localparam int WORD_W = SRC_W + PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              cmd_ready,
    input  logic              dlv_valid,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRIO_W-1:0] dlv_prio,
    output logic              dlv_ready,
    output logic              irq_out,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              resend_req,
    output logic              acc_valid,
    output logic [WORD_W-1:0] acc_word,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src
);
    ipc_state_e        state;
    ipc_op_e           op;
    logic [WORD_W-1:0] op_word;
    logic              take_cmd, take_dlv;
    logic [PRIO_W-1:0] cur_cppr, cur_pprio, cur_mfrr;
    logic [SRC_W-1:0]  cur_src;
    logic              cur_irq;
    logic [PRIO_W-1:0] n_cppr, n_pprio, n_mfrr;
    logic [SRC_W-1:0]  n_src;
    logic              n_irq;
    logic              rej_fire, resend_fire, want_resend, acc_fire, eoi_fire;
    logic [SRC_W-1:0]  rej_id, eoi_id;
    logic [WORD_W-1:0] acc_snap;
    logic              engine_busy;

    assign irq_out     = cur_irq;
    assign engine_busy = (state != ST_IDLE);

    ipc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .dlv_valid(dlv_valid),
        .want_resend(want_resend), .state(state), .cmd_ready(cmd_ready),
        .dlv_ready(dlv_ready), .take_cmd(take_cmd), .take_dlv(take_dlv)
    );

    ipc_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_eval (
        .state(state), .op(op), .op_word(op_word),
        .cur_cppr(cur_cppr), .cur_src(cur_src), .cur_pprio(cur_pprio),
        .cur_mfrr(cur_mfrr), .cur_irq(cur_irq),
        .n_cppr(n_cppr), .n_src(n_src), .n_pprio(n_pprio), .n_mfrr(n_mfrr), .n_irq(n_irq),
        .rej_fire(rej_fire), .rej_id(rej_id), .resend_fire(resend_fire),
        .want_resend(want_resend), .acc_fire(acc_fire), .acc_snap(acc_snap),
        .eoi_fire(eoi_fire), .eoi_id(eoi_id)
    );

    ipc_regs #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .take_cmd(take_cmd), .take_dlv(take_dlv),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
        .n_cppr(n_cppr), .n_src(n_src), .n_pprio(n_pprio), .n_mfrr(n_mfrr), .n_irq(n_irq),
        .rej_fire(rej_fire), .rej_id(rej_id), .resend_fire(resend_fire),
        .acc_fire(acc_fire), .acc_snap(acc_snap), .eoi_fire(eoi_fire), .eoi_id(eoi_id),
        .op(op), .op_word(op_word),
        .cur_cppr(cur_cppr), .cur_src(cur_src), .cur_pprio(cur_pprio),
        .cur_mfrr(cur_mfrr), .cur_irq(cur_irq),
        .rej_valid(rej_valid), .rej_src(rej_src), .resend_req(resend_req),
        .acc_valid(acc_valid), .acc_word(acc_word), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
    parameter int SRC_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [SRC_W-1:0] pend_src,
    input logic             rej_valid,
    input logic             resend_req,
    input logic             acc_valid,
    input logic             dlv_ready,
    input logic             cmd_ready,
    input logic             busy
);
    // R4: a raised line always has a pending source behind it
    a_r4_irq_has_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_src != '0));

    // R2: a pending source is always presented on the line
    a_r2_src_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_src != '0) |-> irq);

    // R5: after an accept the slot is empty and the line is low
    a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ((pend_src == '0) && !irq));

    // R12: reject and resend pulses last one cycle
    a_r12_reject_single: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |=> !rej_valid);
    a_r12_resend_single: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |=> !resend_req);

    // R11: nothing is taken while an operation is in flight
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!dlv_ready && !cmd_ready));
endmodule

bind intr_present_ctrl ipc_checker #(.SRC_W(SRC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq_out), .pend_src(cur_src),
    .rej_valid(rej_valid), .resend_req(resend_req), .acc_valid(acc_valid),
    .dlv_ready(dlv_ready), .cmd_ready(cmd_ready), .busy(engine_busy)
);

// File: tb/intr_present_ctrl_tb.sv
module intr_present_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IPI_ID     = 2;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready;
    logic        dlv_valid = 1'b0;
    logic [23:0] dlv_src = '0;
    logic [7:0]  dlv_prio = '0;
    logic        dlv_ready;
    logic        irq_out, rej_valid, resend_req, acc_valid, eoi_valid;
    logic [23:0] rej_src, eoi_src;
    logic [31:0] acc_word;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // reference model state
    logic [7:0]  m_cppr, m_pp, m_mfrr;
    logic [23:0] m_src;
    logic        m_irq;
    int          e_rej_n, e_res_n;
    logic [23:0] e_rej_src, e_eoi;
    logic [31:0] e_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_present_ctrl #(.IPI_SRC(IPI_ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready), .dlv_valid(dlv_valid),
        .dlv_src(dlv_src), .dlv_prio(dlv_prio), .dlv_ready(dlv_ready),
        .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
        .resend_req(resend_req), .acc_valid(acc_valid), .acc_word(acc_word),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic m_reject(input logic [23:0] s);
        e_rej_n++;
        e_rej_src = s;
    endtask

    task automatic m_ipi_check(input logic [7:0] mv);
        if (!(m_src != 0 && m_pp <= mv)) begin
            if (m_src != 0) m_reject(m_src);
            m_src = 24'(IPI_ID);
            m_pp  = mv;
            m_irq = 1'b1;
        end
    endtask

    task automatic m_resend();
        if (m_mfrr < m_cppr) m_ipi_check(m_mfrr);
        e_res_n++;
    endtask

    // kind: 0 cppr, 1 ipi, 2 accept, 3 eoi, 4 delivery
    task automatic model(input int kind, input logic [31:0] d);
        logic [7:0] old;
        e_rej_n = 0; e_res_n = 0; e_acc = 'x; e_eoi = 'x; e_rej_src = 'x;
        case (kind)
            0: begin
                old = m_cppr; m_cppr = d[7:0];
                if (d[7:0] < old) begin
                    if (m_src != 0 && d[7:0] <= m_pp) begin
                        m_reject(m_src); m_src = 0; m_irq = 1'b0;
                    end
                end else if (m_src == 0) m_resend();
            end
            1: begin
                m_mfrr = d[7:0];
                if (d[7:0] < m_cppr) m_ipi_check(d[7:0]);
            end
            2: begin
                e_acc = {m_cppr, m_src};
                m_cppr = m_pp; m_src = 0; m_irq = 1'b0;
            end
            3: begin
                e_eoi = d[23:0];
                m_cppr = d[31:24];
                if (m_src == 0) m_resend();
            end
            default: begin
                if (d[31:24] >= m_cppr || (m_src != 0 && m_pp <= d[31:24])) m_reject(d[23:0]);
                else begin
                    if (m_src != 0) m_reject(m_src);
                    m_src = d[23:0]; m_pp = d[31:24]; m_irq = 1'b1;
                end
            end
        endcase
    endtask

    task automatic run_op(input string tag, input int kind, input logic [31:0] d, input bit probe);
        int rej_n = 0, res_n = 0, iters = 0;
        logic [23:0] got_rej = 'x, got_eoi = 'x;
        logic [31:0] got_acc = 'x;
        model(kind, d);
        @(negedge clk);
        if (kind == 4) begin
            dlv_valid = 1'b1; dlv_src = d[23:0]; dlv_prio = d[31:24];
            if (probe) begin
                cmd_valid = 1'b1; cmd_op = 2'd2;
                #1;
                chk("R11 delivery wins, cmd_ready", {31'd0, cmd_ready}, 32'd0);
                chk("R11 delivery wins, dlv_ready", {31'd0, dlv_ready}, 32'd1);
                cmd_valid = 1'b0;
            end
        end else begin
            cmd_valid = 1'b1; cmd_op = 2'(kind); cmd_data = d;
        end
        @(posedge clk);
        do begin
            @(negedge clk);
            cmd_valid = 1'b0; dlv_valid = 1'b0;
            iters++;
            if (iters == 1)
                chk({tag, " R11 busy"}, {30'd0, cmd_ready, dlv_ready}, 32'd0);
            if (rej_valid) begin rej_n++; got_rej = rej_src; end
            if (resend_req) res_n++;
            if (acc_valid) got_acc = acc_word;
            if (eoi_valid) got_eoi = eoi_src;
        end while (!dlv_ready && iters < 20);
        chk({tag, " R11 latency"}, iters, (e_res_n != 0) ? 3 : 2);
        chk({tag, " R3 R4 R6 R9 reject count"}, rej_n, e_rej_n);
        if (e_rej_n != 0) chk({tag, " R3 R4 R6 R9 reject src"}, {8'd0, got_rej}, {8'd0, e_rej_src});
        chk({tag, " R7 R10 resend count"}, res_n, e_res_n);
        chk({tag, " R4 R9 irq line"}, {31'd0, irq_out}, {31'd0, m_irq});
        if (kind == 2) chk({tag, " R5 R2 accept word"}, got_acc, e_acc);
        if (kind == 3) chk({tag, " R10 eoi src"}, {8'd0, got_eoi}, {8'd0, e_eoi});
    endtask

    function automatic logic [7:0] rnd_prio();
        int r = $urandom % 11;
        return (r >= 9) ? 8'hFF : 8'(r);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        m_cppr = 0; m_src = 0; m_pp = 0; m_mfrr = 8'hFF; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset irq", {31'd0, irq_out}, 32'd0);
        chk("R1 reset ready", {30'd0, cmd_ready, dlv_ready}, 32'd3);

        run_op("R1 accept after reset", 2, 32'd0, 0);
        run_op("R1 R7 raise priority, no IPI", 0, 32'h0000_00FF, 0);
        run_op("R4 first delivery", 4, 32'h0400_0005, 0);
        run_op("R3 equal priority rejected", 4, 32'h0400_0006, 0);
        run_op("R4 displace", 4, 32'h0200_0007, 1);
        run_op("R6 lower, keep", 0, 32'h0000_0003, 0);
        run_op("R6 lower to equal, eject", 0, 32'h0000_0002, 0);
        run_op("R8 R9 IPI latch", 1, 32'h0000_0001, 0);
        run_op("R5 accept IPI", 2, 32'd0, 0);
        run_op("R10 eoi reopens IPI", 3, 32'hFF00_0002, 0);
        run_op("R3 masked delivery", 4, 32'hFF00_0009, 0);
        run_op("R8 IPI masked", 1, 32'h0000_00FF, 0);

        for (int i = 0; i < 600; i++) begin
            int k = $urandom % 5;
            logic [31:0] d;
            if (k == 4)      d = {rnd_prio(), 24'(1 + $urandom % 30)};
            else if (k == 3) d = {rnd_prio(), 24'($urandom % 30)};
            else             d = {24'd0, rnd_prio()};
            run_op("random", k, d, (i % 7) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule